// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches 16-bit words from a 64-word serial EEPROM that has three control wires: chip select, shift clock and serial data toward the memory. A fourth wire carries serial data back from the memory. A host presents a 6-bit word address together with a one-cycle start strobe. The block then produces the read command on the wires and collects the reply. The word appears on a 16-bit output together with a one-cycle done pulse.

A second request input starts a sweep. A sweep reads every word from address 0 through 63 in rising order and keeps a 16-bit sum of them that wraps on overflow. It also builds a 48-bit station address out of the first three words. The serial clock is derived from the system clock. A parameter sets how many system cycles each half of the serial clock period lasts.

Top module: `sprom_reader`

## Requirements
- R1: After reset, busy_o, done_o, sweep_done_o, cs_o, sk_o, di_o, data_o, sum_o and mac_o are all zero.
- R2: A start_i pulse while busy_o is low and sweep_i is low starts one access. busy_o is high from the next cycle until the access ends. done_o is then high for exactly one cycle and data_o holds the addressed word.
- R3: Each access sends 11 command bits on di_o, most significant first. The bits are two zeros, a one (start bit), a one and a zero (read opcode), and then the 6 address bits from bit 5 down to bit 0.
- R4: Throughout an access cs_o stays high. di_o changes only while sk_o is low, and it is held steady for as long as sk_o is high.
- R5: After the command, 16 more rising edges of sk_o clock the data in. do_i is sampled while sk_o is high, and the first bit taken is data bit 15. Each access has 27 rising edges of sk_o in total.
- R6: When an access ends, cs_o, sk_o and di_o all fall low together, and they stay low while no access runs.
- R7: Each half of the serial clock lasts HALF_DIV system cycles. done_o rises 54*HALF_DIV cycles after the clock edge that accepts the start.
- R8: A start_i or sweep_i pulse that arrives while busy_o is high is ignored. It starts no access and does not change the result of the access in flight.
- R9: A sweep_i pulse while idle reads addresses 0 to 63 in order, with one done_o pulse per word. busy_o stays high for the whole sweep. sweep_done_o then pulses for one cycle, busy_o falls in that same cycle, and sum_o holds the 16-bit wrapping sum of all 64 words.
- R10: When a sweep ends, mac_o = {w0[7:0], w0[15:8], w1[7:0], w1[15:8], w2[7:0], w2[15:8]}, where wN is the word at address N. Station byte i comes from word i/2: even bytes take the low half of that word and odd bytes the high half. Byte 0 is in mac_o[47:40].
- R11: If start_i and sweep_i are both high in the same idle cycle, the sweep is performed and the single read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Single-word read request (one-cycle pulse) |
| sweep_i | input | 1 | Full-memory sweep request (one-cycle pulse) |
| addr_i | input | 6 | Word address for a single read |
| busy_o | output | 1 | High while an access or a sweep is running |
| done_o | output | 1 | One-cycle pulse when data_o holds a new word |
| data_o | output | 16 | Last word read |
| sweep_done_o | output | 1 | One-cycle pulse at the end of a sweep |
| sum_o | output | 16 | Wrapping sum from the last sweep |
| mac_o | output | 48 | Station address from the last sweep |
| cs_o | output | 1 | EEPROM chip select |
| sk_o | output | 1 | EEPROM shift clock |
| di_o | output | 1 | Serial data toward the EEPROM |
| do_i | input | 1 | Serial data from the EEPROM |

## Verification
Two requests can meet in one cycle, and the bench makes them do so on purpose. In the first case, a single read and a sweep are raised together in an idle cycle. The bench judges this by the first word returned, which must come from address 0 rather than from the single-read address, by the count of 64 done pulses, and by the final sum. In the second case, a new start is raised in the very cycle that done_o reports the previous word. Here the memory model records the command it receives, and the bench checks that this command carries the new address and that the second word arrives on time.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;
  localparam int WORDS   = 1 << ADDR_W;
  localparam int CMD_W   = 11;
  localparam int OP_W    = 3;
  localparam int PAD_W   = CMD_W - OP_W - ADDR_W;
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int MAC_W   = 48;
  localparam int MAC_WORDS = MAC_W / DATA_W;
  localparam logic [OP_W-1:0] RD_OP = 3'b110;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_DAT} phase_e;

  function automatic logic [CMD_W-1:0] rd_cmd(input logic [ADDR_W-1:0] a);
    return {{PAD_W{1'b0}}, RD_OP, a};
  endfunction
endpackage

// File: rtl/sprom_clkgen.sv
module sprom_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick_o = en_i;
    end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || !en_i) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end

      assign tick_o = en_i && (cnt == LAST);

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R7
    end
  endgenerate
endmodule

// File: rtl/sprom_shift.sv
module sprom_shift
  import sprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tick_i,
  input  logic              do_i,
  output logic              busy_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              wdone_o,
  output logic [DATA_W-1:0] wdata_o
);
  phase_e             st;
  logic               hi;
  logic [IDX_W-1:0]   idx;
  logic [CMD_W-1:0]   cmd_q;
  logic [DATA_W-1:0]  shreg;
  logic [CMD_W-1:0]   cmd_new;

  assign cmd_new = rd_cmd(addr_i);
  assign busy_o  = (st != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PH_IDLE;
      hi      <= 1'b0;
      idx     <= '0;
      cmd_q   <= '0;
      shreg   <= '0;
      cs_o    <= 1'b0;
      sk_o    <= 1'b0;
      di_o    <= 1'b0;
      wdone_o <= 1'b0;
      wdata_o <= '0;
    end else begin
      wdone_o <= 1'b0;
      unique case (st)
        PH_IDLE: begin
          if (req_i) begin
            st    <= PH_CMD;
            cmd_q <= cmd_new;
            idx   <= IDX_W'(CMD_W - 1);
            hi    <= 1'b0;
            cs_o  <= 1'b1;
            sk_o  <= 1'b0;
            di_o  <= cmd_new[CMD_W-1];
          end
        end
        PH_CMD: begin
          if (tick_i) begin
            if (!hi) begin
              hi   <= 1'b1;
              sk_o <= 1'b1;
            end else begin
              hi   <= 1'b0;
              sk_o <= 1'b0;
              if (idx == '0) begin
                st   <= PH_DAT;
                idx  <= IDX_W'(DATA_W - 1);
                di_o <= 1'b0;
              end else begin
                idx  <= idx - 1'b1;
                di_o <= cmd_q[idx - 1'b1];
              end
            end
          end
        end
        PH_DAT: begin
          if (tick_i) begin
            if (!hi) begin
              hi   <= 1'b1;
              sk_o <= 1'b1;
            end else begin
              hi    <= 1'b0;
              sk_o  <= 1'b0;
              shreg <= {shreg[DATA_W-2:0], do_i};
              if (idx == '0) begin
                st      <= PH_IDLE;
                cs_o    <= 1'b0;
                wdone_o <= 1'b1;
                wdata_o <= {shreg[DATA_W-2:0], do_i};
              end else begin
                idx <= idx - 1'b1;
              end
            end
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    sk_o |-> cs_o); // R4
  AST_DI_SETUP_HELD: assert property (@(posedge clk) disable iff (rst)
    sk_o |-> $stable(di_o)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == PH_IDLE) |-> (!cs_o && !sk_o && !di_o)); // R6
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && req_i) |=> $stable(cmd_q)); // R8
endmodule

// File: rtl/sprom_sweep.sv
module sprom_sweep
  import sprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic              wdone_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              active_o,
  output logic              launch_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sweep_done_o,
  output logic [DATA_W-1:0] sum_o,
  output logic [MAC_W-1:0]  mac_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o     <= 1'b0;
      launch_o     <= 1'b0;
      addr_o       <= '0;
      sweep_done_o <= 1'b0;
      sum_o        <= '0;
      mac_o        <= '0;
    end else begin
      launch_o     <= 1'b0;
      sweep_done_o <= 1'b0;
      if (!active_o) begin
        if (go_i) begin
          active_o <= 1'b1;
          launch_o <= 1'b1;
          addr_o   <= '0;
          sum_o    <= '0;
        end
      end else if (wdone_i) begin
        sum_o <= sum_o + wdata_i;
        for (int k = 0; k < MAC_WORDS; k++) begin
          if (addr_o == ADDR_W'(k))
            mac_o[MAC_W-1-DATA_W*k -: DATA_W] <= {wdata_i[7:0], wdata_i[15:8]};
        end
        if (addr_o == LAST) begin
          active_o     <= 1'b0;
          sweep_done_o <= 1'b1;
        end else begin
          addr_o   <= addr_o + 1'b1;
          launch_o <= 1'b1;
        end
      end
    end
  end

  AST_SWEEP_ORDER: assert property (@(posedge clk) disable iff (rst)
    (active_o && wdone_i && addr_o != LAST) |=> (addr_o == $past(addr_o) + 1'b1)); // R9
  AST_LAUNCH_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    launch_o |-> active_o); // R9
endmodule

// File: rtl/sprom_reader.sv
module sprom_reader #(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        sweep_i,
  input  logic [5:0]  addr_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] data_o,
  output logic        sweep_done_o,
  output logic [15:0] sum_o,
  output logic [47:0] mac_o,
  output logic        cs_o,
  output logic        sk_o,
  output logic        di_o,
  input  logic        do_i
);
  import sprom_pkg::*;

  logic              sh_busy, tick, sw_active, sw_launch;
  logic              single_go, sweep_go, sh_req;
  logic [ADDR_W-1:0] sw_addr, sh_addr;

  assign busy_o    = sh_busy | sw_active;
  assign sweep_go  = sweep_i & ~busy_o;
  assign single_go = start_i & ~busy_o & ~sweep_i;
  assign sh_req    = single_go | sw_launch;
  assign sh_addr   = sw_active ? sw_addr : addr_i;

  sprom_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .en_i(sh_busy), .tick_o(tick)
  );

  sprom_shift u_shift (
    .clk(clk), .rst(rst), .req_i(sh_req), .addr_i(sh_addr), .tick_i(tick),
    .do_i(do_i), .busy_o(sh_busy), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o),
    .wdone_o(done_o), .wdata_o(data_o)
  );

  sprom_sweep u_sweep (
    .clk(clk), .rst(rst), .go_i(sweep_go), .wdone_i(done_o), .wdata_i(data_o),
    .active_o(sw_active), .launch_o(sw_launch), .addr_o(sw_addr),
    .sweep_done_o(sweep_done_o), .sum_o(sum_o), .mac_o(mac_o)
  );

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R2
  AST_SWEEP_END_IDLE: assert property (@(posedge clk) disable iff (rst)
    sweep_done_o |-> !busy_o); // R9
  AST_SWEEP_WINS: assert property (@(posedge clk) disable iff (rst)
    (start_i && sweep_i && !busy_o) |=> sw_active); // R11
endmodule

// File: tb/sprom_reader_test.sv
module sprom_reader_test;
  localparam int D = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, sweep_i = 1'b0;
  logic [5:0] addr_i = '0;
  logic busy_o, done_o, sweep_done_o, cs_o, sk_o, di_o, do_i;
  logic [15:0] data_o, sum_o;
  logic [47:0] mac_o;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  sprom_reader #(.HALF_DIV(D)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .sweep_i(sweep_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .data_o(data_o), .sweep_done_o(sweep_done_o),
    .sum_o(sum_o), .mac_o(mac_o), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .do_i(do_i)
  );

  function automatic logic [15:0] wf(input int a);
    return 16'((a * 40503) ^ 16'h3C5A ^ (a << 11));
  endfunction

  // memory model
  int r = 0, acc = 0, last_rises = 0;
  logic [10:0] mcmd = '0, last_cmd = '0;
  logic [15:0] mw;
  assign mw   = wf(int'(mcmd[5:0]));
  assign do_i = (r >= 12 && r <= 27) ? mw[27 - r] : 1'b0;

  always @(posedge sk_o or negedge cs_o) begin
    if (!cs_o) begin
      last_rises = r;
      last_cmd   = mcmd;
      r          = 0;
    end else begin
      if (r == 0) acc++;
      if (r < 11) mcmd = {mcmd[9:0], di_o};
      r++;
    end
  end

  // line monitors
  logic p_sk = 0, p_di = 0, p_cs = 0;
  int bad_setup = 0, bad_end = 0;
  always @(negedge clk) begin
    cycles++;
    if (p_sk && sk_o && di_o != p_di) bad_setup++;
    if (sk_o && !cs_o) bad_setup++;
    if (p_cs && !cs_o && (sk_o || di_o)) bad_end++;
    p_sk = sk_o; p_di = di_o; p_cs = cs_o;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // caller is at a negedge; drives start now
  task automatic do_read(input logic [5:0] a, output logic [15:0] d, output int lat);
    addr_i = a; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    lat = 0;
    chk(busy_o == 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
    while (!done_o && lat < 5000) begin @(negedge clk); lat++; end
    d = data_o;
  endtask

  task automatic t_reset;
    chk({busy_o, done_o, sweep_done_o, cs_o, sk_o, di_o} == 6'b0, "R1 control outs",
        64'({busy_o, done_o, sweep_done_o, cs_o, sk_o, di_o}), 64'd0);
    chk(data_o == 0 && sum_o == 0 && mac_o == 0, "R1 data outs", 64'(mac_o ^ data_o ^ sum_o), 64'd0);
  endtask

  task automatic t_single(input logic [5:0] a);
    logic [15:0] d; int lat;
    do_read(a, d, lat);
    chk(d == wf(a), "R2 word value", 64'(d), 64'(wf(a)));
    chk(lat == 54 * D, "R7 latency", 64'(lat), 64'(54 * D));
    @(negedge clk);
    chk(!done_o, "R2 done one cycle", 64'(done_o), 64'd0);
    chk(last_cmd == {2'b00, 3'b110, a}, "R3 command bits", 64'(last_cmd), 64'({2'b00, 3'b110, a}));
    chk(last_rises == 27, "R5 rising edges", 64'(last_rises), 64'd27);
    chk(!cs_o && !sk_o && !di_o, "R6 idle lines", 64'({cs_o, sk_o, di_o}), 64'd0);
  endtask

  task automatic t_back_to_back;
    logic [15:0] d; int lat;
    do_read(6'd17, d, lat);
    do_read(6'd42, d, lat);
    chk(d == wf(42), "R2 start on done cycle", 64'(d), 64'(wf(42)));
    chk(lat == 54 * D, "R7 back-to-back latency", 64'(lat), 64'(54 * D));
    chk(last_cmd[5:0] == 6'd42, "R3 second address", 64'(last_cmd[5:0]), 64'd42);
    @(negedge clk);
  endtask

  task automatic t_ignore_busy;
    int a0 = acc, lat = 0, sd = 0;
    addr_i = 6'd9; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    addr_i = 6'd50; start_i = 1'b1; sweep_i = 1'b1;
    @(negedge clk); start_i = 1'b0; sweep_i = 1'b0;
    while (!done_o && lat < 5000) begin @(negedge clk); lat++; end
    chk(data_o == wf(9), "R8 data unaffected", 64'(data_o), 64'(wf(9)));
    chk(last_cmd[5:0] == 6'd9, "R8 address kept", 64'(last_cmd[5:0]), 64'd9);
    repeat (300) begin @(negedge clk); if (sweep_done_o || busy_o) sd++; end
    chk(acc == a0 + 1, "R8 one access only", 64'(acc - a0), 64'd1);
    chk(sd == 0, "R8 no sweep started", 64'(sd), 64'd0);
  endtask

  task automatic t_sweep(input logic with_start);
    int n = 0, bad = 0, guard = 0, busylow = 0;
    logic [15:0] es = '0;
    logic [15:0] w0, w1, w2;
    logic [47:0] em;
    for (int k = 0; k < 64; k++) es += wf(k);
    w0 = wf(0); w1 = wf(1); w2 = wf(2);
    em = {w0[7:0], w0[15:8], w1[7:0], w1[15:8], w2[7:0], w2[15:8]};
    addr_i = 6'd5; sweep_i = 1'b1; start_i = with_start;
    @(negedge clk); sweep_i = 1'b0; start_i = 1'b0;
    while (!sweep_done_o && guard < 40000) begin
      if (!busy_o) busylow++;
      if (done_o) begin
        if (data_o != wf(n)) bad++;
        n++;
      end
      @(negedge clk); guard++;
    end
    chk(n == 64, with_start ? "R11 word count" : "R9 word count", 64'(n), 64'd64);
    chk(bad == 0, with_start ? "R11 order from zero" : "R9 order", 64'(bad), 64'd0);
    chk(busylow == 0, "R9 busy through sweep", 64'(busylow), 64'd0);
    chk(!busy_o, "R9 busy falls with sweep_done", 64'(busy_o), 64'd0);
    chk(sum_o == es, "R9 sum", 64'(sum_o), 64'(es));
    chk(mac_o == em, "R10 station address", 64'(mac_o), 64'(em));
    @(negedge clk);
    chk(!sweep_done_o, "R9 sweep_done one cycle", 64'(sweep_done_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single(6'd0);
    t_single(6'd63);
    t_single(6'h2A);
    t_back_to_back();
    t_ignore_busy();
    t_sweep(1'b0);
    t_sweep(1'b1);
    chk(bad_setup == 0, "R4 data held while clock high", 64'(bad_setup), 64'd0);
    chk(bad_end == 0, "R6 lines low at end", 64'(bad_end), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule